// File: doc/BRIEF.md
# Multi-format audio serial port

This block is the slave side of a stereo audio serial link. An external bit clock and an external frame clock set the timing. The block receives a left and a right sample on one serial input and sends a left and a right sample on one serial output. Both clocks are oversampled by a faster system clock. Each of them passes through a synchronizer, and the bit clock is then edge-detected. All shifting, bit placement and word capture run in the system clock domain.

A 2-bit format select picks one of four frame layouts. Within one setting, the receive layout can differ from the transmit layout.

- **Transmit side.** It always sends 20 bits, MSB first, in one of two layouts. In the first layout the MSB sits in the first slot of the half-frame. In the second (I2S) layout the MSB sits one slot later. Transmit words enter in parallel and are latched at the start of each left half-frame. A strobe marks the moment of capture.
- **Receive side.** It is either MSB-aligned or aligned to the end of the half-frame (LSB-justified). The LSB-justified layouts take 16-bit or 20-bit words. For these layouts the block places the bits using the length of the previous half-frame.
- **Receive output.** Received left and right words come out together, with a one-cycle strobe, once the right half-frame has ended.

Top module: `aud_serial_port`

## Requirements
- R1: While reset is asserted, sdout, tx_take and rx_valid are 0, and rx_left and rx_right are all zeros.
- R2: With fmt = 2'b00, the frame clock high marks the left half. Receive takes a 16-bit word that ends in the last slot of the half-frame. That word is delivered as bits 19..4 of the 20-bit output, with bits 3..0 set to zero.
- R3: With fmt = 2'b01, the frame clock high marks the left half. Receive takes a 20-bit word that ends in the last slot of the half-frame.
- R4: With fmt = 2'b10, receive takes the word MSB first, starting in slot 0 after a frame clock change. A word whose low bits are sent as zeros (16 data bits plus 4 zeros, or 18 plus 2) is accepted unchanged.
- R5: With fmt = 2'b11, both directions put the MSB in slot 1 after a frame clock change. In this setting the frame clock low marks the left half.
- R6: For fmt 00, 01 and 10, transmit sends bit 19 in slot 0, then bits 18 down to 0 in slots 1 to 19. Every later slot of the half-frame carries 0.
- R7: With a 16-slot half-frame, only bits 19..4 are sent. An MSB-aligned receive then returns those bits with bits 3..0 set to zero.
- R8: rx_valid is a one-cycle pulse that follows the frame clock change that ends a right half-frame. It carries the words of that frame's left and right halves. No pulse is produced for a frame whose left half began before a full half-frame length had been measured.
- R9: tx_take pulses once at the start of each left half-frame. tx_left and tx_right are sampled at that moment and used for the whole frame.
- R10: sdout changes only in response to a bit clock falling edge, and it holds steady while the bit clock is high. sdin is sampled on bit clock rising edges.
- R11: LSB-justified receive finds where the word starts by using the slot count of the preceding half-frame. This works for any half-frame length up to MAX_HALF_SLOTS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Frame layout select |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame (channel) clock |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_left | input | 20 | Left word to send |
| tx_right | input | 20 | Right word to send |
| tx_take | output | 1 | Pulse when the transmit words are latched |
| rx_left | output | 20 | Last received left word |
| rx_right | output | 20 | Last received right word |
| rx_valid | output | 1 | One-cycle pulse when rx_left/rx_right update |

## Verification
Each failure mode of the internal state shows up at the ports within a known time:

- **Slot counter or channel tracker.** A slip here shows within one half-frame, as a serial output pattern shifted by a slot. In the 16-slot case it shows as a wrong truncation point.
- **Measured half-frame length.** A wrong length misplaces LSB-justified bits on the very next half. The word delivered with the following rx_valid then comes out rotated or masked.
- **Word hold registers.** A fault in these registers or in the pairing of the two halves shows on the next rx_valid pulse. It appears as swapped channels, a missing pulse or an extra pulse.
- **Frame-clock polarity.** A polarity error in the I2S setting exchanges the two channels in both directions at once.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int WORD_W  = 20;
  localparam int SHORT_W = 16;
  localparam int IDX_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {
    FMT_L16 = 2'b00,
    FMT_L20 = 2'b01,
    FMT_MSB = 2'b10,
    FMT_I2S = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } bitsel_t;

  // Which word bit travels in a given slot for the transmit layouts
  // (and for the MSB-aligned receive layouts, which match them).
  function automatic bitsel_t msb_sel(fmt_e f, int slot);
    bitsel_t r;
    int p;
    r = '0;
    p = (f == FMT_I2S) ? slot - 1 : slot;
    if (p >= 0 && p < WORD_W) begin
      r.hit = 1'b1;
      r.idx = IDX_W'(WORD_W - 1 - p);
    end
    return r;
  endfunction

  // Receive bit placement; the LSB-justified layouts count back from the
  // end of the half-frame using the previous half-frame length.
  function automatic bitsel_t rx_sel(fmt_e f, int slot, int len);
    bitsel_t r;
    int p;
    r = '0;
    p = len - 1 - slot;
    case (f)
      FMT_L16: if (slot < len && p >= 0 && p < SHORT_W) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(p + WORD_W - SHORT_W);
      end
      FMT_L20: if (slot < len && p >= 0 && p < WORD_W) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(p);
      end
      default: r = msb_sel(f, slot);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= din;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/asp_frame_track.sv
module asp_frame_track #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_lvl,
  input  logic              lrck_lvl,
  output logic              bclk_rise,
  output logic              slot_start,
  output logic              new_half,
  output logic              lr_cur,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] len,
  output logic              len_ok
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic bclk_d;
  logic synced;
  logic bclk_fall;
  logic trans;

  assign bclk_rise = bclk_lvl & ~bclk_d;
  assign bclk_fall = ~bclk_lvl & bclk_d;
  assign trans     = bclk_fall && (lrck_lvl != lr_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d     <= 1'b0;
      slot_start <= 1'b0;
      new_half   <= 1'b0;
      lr_cur     <= 1'b0;
      synced     <= 1'b0;
      slot       <= SLOT_MAX;
      len        <= '0;
      len_ok     <= 1'b0;
    end else begin
      bclk_d     <= bclk_lvl;
      slot_start <= bclk_fall;
      new_half   <= trans;
      if (!synced || bclk_fall) lr_cur <= lrck_lvl;
      if (trans) begin
        slot   <= '0;
        synced <= 1'b1;
        len_ok <= len_ok | synced;
        if (synced) len <= (slot == SLOT_MAX) ? SLOT_MAX : slot + 1'b1;
      end else if (bclk_fall && slot != SLOT_MAX) begin
        slot <= slot + 1'b1;
      end
    end
  end

  AST_SLOT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !new_half) |-> (slot != '0)); // R11
  AST_HALF_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    new_half |-> (slot_start && slot == '0)); // R6
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int SLOT_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  asp_pkg::fmt_e              fmt,
  input  logic [SLOT_W-1:0]          slot,
  input  logic                       slot_start,
  input  logic                       new_half,
  input  logic                       chan_left,
  input  logic [asp_pkg::WORD_W-1:0] tx_left,
  input  logic [asp_pkg::WORD_W-1:0] tx_right,
  output logic                       tx_take,
  output logic                       sdout
);
  import asp_pkg::*;

  logic [WORD_W-1:0] hold_l, hold_r, word;
  bitsel_t sel;

  assign tx_take = new_half && chan_left;
  assign word    = chan_left ? (tx_take ? tx_left : hold_l) : hold_r;
  assign sel     = msb_sel(fmt, int'(slot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sdout  <= 1'b0;
    end else begin
      if (tx_take) begin
        hold_l <= tx_left;
        hold_r <= tx_right;
      end
      if (slot_start) sdout <= sel.hit ? word[sel.idx] : 1'b0;
    end
  end

  AST_SDOUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable(sdout)); // R10
  AST_SDOUT_PAST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !sel.hit) |=> !sdout); // R6
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int SLOT_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  asp_pkg::fmt_e              fmt,
  input  logic [SLOT_W-1:0]          slot,
  input  logic [SLOT_W-1:0]          len,
  input  logic                       len_ok,
  input  logic                       bclk_rise,
  input  logic                       new_half,
  input  logic                       chan_left,
  input  logic                       sdin,
  output logic [asp_pkg::WORD_W-1:0] rx_left,
  output logic [asp_pkg::WORD_W-1:0] rx_right,
  output logic                       rx_valid
);
  import asp_pkg::*;

  logic [WORD_W-1:0] acc, left_hold;
  logic cur_good, left_good;
  bitsel_t sel;

  assign sel = rx_sel(fmt, int'(slot), int'(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      left_hold <= '0;
      cur_good  <= 1'b0;
      left_good <= 1'b0;
      rx_left   <= '0;
      rx_right  <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (new_half) begin
        if (!chan_left) begin
          left_hold <= acc;
          left_good <= cur_good;
        end else begin
          if (cur_good && left_good) begin
            rx_left  <= left_hold;
            rx_right <= acc;
            rx_valid <= 1'b1;
          end
          left_good <= 1'b0;
        end
        acc      <= '0;
        cur_good <= len_ok;
      end else if (bclk_rise && sel.hit) begin
        acc[sel.idx] <= sdin;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
  AST_WORDS_CHANGE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_right) |-> rx_valid); // R8
  AST_VALID_NEEDS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> len_ok); // R8
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port #(
  parameter int SYNC_STAGES    = 2,
  parameter int MAX_HALF_SLOTS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdin,
  output logic        sdout,
  input  logic [19:0] tx_left,
  input  logic [19:0] tx_right,
  output logic        tx_take,
  output logic [19:0] rx_left,
  output logic [19:0] rx_right,
  output logic        rx_valid
);
  import asp_pkg::*;

  localparam int SLOT_W = $clog2(MAX_HALF_SLOTS) + 1;

  logic [1:0]        clk_pair;
  logic              bclk_rise, slot_start, new_half, lr_cur, len_ok, chan_left;
  logic [SLOT_W-1:0] slot, len;
  fmt_e              fmt_sel;

  assign fmt_sel   = fmt_e'(fmt);
  assign chan_left = (fmt_sel == FMT_I2S) ? ~lr_cur : lr_cur;

  asp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({lrclk, bclk}), .dout(clk_pair)
  );

  asp_frame_track #(.SLOT_W(SLOT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bclk_lvl(clk_pair[0]), .lrck_lvl(clk_pair[1]),
    .bclk_rise(bclk_rise), .slot_start(slot_start), .new_half(new_half),
    .lr_cur(lr_cur), .slot(slot), .len(len), .len_ok(len_ok)
  );

  asp_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_sel), .slot(slot), .slot_start(slot_start),
    .new_half(new_half), .chan_left(chan_left), .tx_left(tx_left),
    .tx_right(tx_right), .tx_take(tx_take), .sdout(sdout)
  );

  asp_rx #(.SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_sel), .slot(slot), .len(len), .len_ok(len_ok),
    .bclk_rise(bclk_rise), .new_half(new_half), .chan_left(chan_left), .sdin(sdin),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  AST_TAKE_ONLY_AT_LEFT_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> !$past(tx_take)); // R9
endmodule

// File: tb/test_aud_serial_port.sv
module test_aud_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic bclk = 1'b1, lrclk = 1'b0, sdin = 1'b0;
  logic sdout, tx_take, rx_valid;
  logic [19:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

  int checks = 0, errors = 0, rxn = 0, takes = 0;
  bit done = 1'b0;
  logic [19:0] exp_l [2];
  logic [19:0] exp_r [2];

  always #2 clk = ~clk;

  aud_serial_port i_aud_serial_port (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .sdout(sdout), .tx_left(tx_left), .tx_right(tx_right), .tx_take(tx_take),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  // Serial image of a word in slot s of an h-slot half-frame.
  function automatic logic in_bit(int f, int h, int s, logic [19:0] w);
    int k;
    logic b;
    b = 1'b0;
    if (f == 0) begin k = s - (h - 16); if (k >= 0 && k < 16) b = w[19-k]; end
    else if (f == 1) begin k = s - (h - 20); if (k >= 0 && k < 20) b = w[19-k]; end
    else if (f == 2) begin if (s < 20) b = w[19-s]; end
    else begin k = s - 1; if (k >= 0 && k < 20) b = w[19-k]; end
    return b;
  endfunction

  // Bits of a received word that survive the layout: top n bits kept.
  function automatic logic [19:0] keep_mask(int f, int h);
    int n;
    if (f == 0) n = 16;
    else if (f == 3) n = (h - 1 < 20) ? h - 1 : 20;
    else n = (h < 20) ? h : 20;
    return ~(20'((32'd1 << (20 - n)) - 32'd1));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_half(int f, int h, bit left, logic [19:0] rw, logic [19:0] tw,
                         bit chk, string req);
    logic [63:0] got, expv;
    int moved;
    got = '0; expv = '0; moved = 0;
    for (int s = 0; s < h; s++) begin
      bclk = 1'b0;
      lrclk = (f == 3) ? !left : left;
      sdin = in_bit(f, h, s, rw);
      repeat (8) @(negedge clk);
      got[s] = sdout;
      expv[s] = in_bit((f == 3) ? 3 : 2, h, s, tw);
      bclk = 1'b1;
      repeat (7) @(negedge clk);
      if (sdout !== got[s]) moved++;
      @(negedge clk);
    end
    if (chk) begin
      check(req, got, expv);
      check("R10 sdout held while bclk high", 64'(moved), 64'd0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxn < 2) begin
        check("R8 rx_left word", 64'(rx_left), 64'(exp_l[rxn]));
        check("R8 rx_right word", 64'(rx_right), 64'(exp_r[rxn]));
      end
      rxn++;
    end
    if (rst_n && tx_take) takes++;
  end

  task automatic run_cfg(int f, int h, int seed, bit zero_low);
    logic [19:0] l, r, tl, tr, m;
    string rq, tq;
    rq = (f == 0) ? "R2 R11 16-bit LSB rx" : (f == 1) ? "R3 R11 20-bit LSB rx" :
         (f == 2) ? "R4 R7 MSB rx" : "R5 I2S rx";
    tq = (f == 3) ? "R5 I2S tx slots" : (h < 20) ? "R7 truncated tx slots" : "R6 MSB tx slots";
    rst_n = 1'b0; fmt = 2'(f); bclk = 1'b1; lrclk = (f == 3); sdin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 64'({sdout, tx_take, rx_valid}), 64'd0);
    check("R1 reset words", 64'({rx_left, rx_right}), 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rxn = 0; takes = 0;
    m = keep_mask(f, h);
    for (int fr = 0; fr < 3; fr++) begin
      l  = 20'h80001 ^ 20'(fr * 32'h2D4B3 + seed * 32'h0F19D);
      r  = ~l ^ 20'h00F0F;
      if (zero_low) begin l = l & 20'hFFFF0; r = r & 20'hFFFC0; end
      tl = l ^ 20'h5A5A5; tr = r ^ 20'hC3C3C;
      if (fr > 0) begin exp_l[fr-1] = l & m; exp_r[fr-1] = r & m; end
      tx_left = tl; tx_right = tr;
      do_half(f, h, 1'b1, l, tl, 1'b1, {tq, " left"});
      do_half(f, h, 1'b0, r, tr, 1'b1, {tq, " right"});
      if (fr == 0) check({rq, " no pulse before measured half"}, 64'(rxn), 64'd0);
    end
    do_half(f, h, 1'b1, '0, '0, 1'b0, "");
    check({rq, " R8 pulse count"}, 64'(rxn), 64'd2);
    check("R9 tx_take count", 64'(takes), 64'd4);
  endtask

  initial begin
    run_cfg(0, 16, 1, 1'b0);
    run_cfg(0, 32, 2, 1'b0);
    run_cfg(1, 20, 3, 1'b0);
    run_cfg(1, 32, 4, 1'b0);
    run_cfg(2, 16, 5, 1'b0);
    run_cfg(2, 32, 6, 1'b0);
    run_cfg(2, 32, 7, 1'b1);
    run_cfg(3, 24, 8, 1'b0);
    run_cfg(3, 32, 9, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule